// File: doc/BRIEF.md
# Adaptive Entropy Coder Option Selector

This block looks at one block of mapped prediction residuals and decides how an adaptive entropy coder should code that block. For each sample it accepts, it keeps running totals for every candidate coding option at the same time. The candidates are:

- a zero-block codeword;
- a pairwise second-extension code;
- the fundamental sequence, which is the split code with k equal to 0;
- split codes with k of 1 and up;
- raw, uncompressed samples.

Once the block is complete, it adds each option's identifier overhead to that option's total. A single comparison across the whole block then picks the cheapest option.

A downstream codeword emitter uses the result. That result is the option kind, the split parameter k, the winning bit count and a flag that says every residual in the block was zero. Run-length handling of consecutive zero blocks and bit packing are left to the emitter.

The control is a four-state machine:

- **IDLE** waits for a block start.
- **FILL** accumulates samples. A block start seen in FILL restarts the block.
- **COST** registers the per-option totals. It is entered from FILL on the last sample.
- **EMIT** performs the comparison. It always returns to IDLE, and the result is registered as it leaves.

Top module: `rice_option_selector`

## Requirements
- R1: While reset is held and after it is released, `out_valid` stays low until a complete block has been accepted.
- R2: A block begins with a sample where `in_valid` and `in_first` are both high. The following samples with `in_valid` high and `in_first` low are added to the block. A sample with `in_first` low that arrives in IDLE is ignored. A sample with `in_first` high that arrives in FILL discards the partial block and starts a new one.
- R3: The split cost for parameter k is the identifier length, plus J·k, plus the sum over the block of (r >> k) + 1. The fundamental sequence is the case k = 0.
- R4: Second extension pairs the residuals in arrival order as (a, b) and computes gamma = (a+b)(a+b+1)/2 + b for each pair. Its cost is the identifier length plus one, plus the sum over the J/2 pairs of gamma + 1.
- R5: The raw cost is J·n plus the identifier length. The reported cost never exceeds this value.
- R6: The identifier length is 3 bits for n ≤ 8, 4 bits for n ≤ 16, and 5 bits otherwise.
- R7: When every residual in the block is zero, `out_allzero` is high. In the full option set the zero-block option is then chosen, at a cost of the identifier length plus 2.
- R8: `out_kind` is encoded as 0 for zero block, 1 for second extension, 2 for split (k on `out_k`) and 3 for raw. `out_k` is 0 for every kind other than split. The lowest total wins. On a tie, the earlier option in the order zero block, second extension, split k = 0, 1, 2, ..., raw is kept.
- R9: With `cfg_restr` high, only split options with k ≤ 3 and raw are candidates.
- R10: In the full set, split options are limited to k ≤ n − 2.
- R11: Residual bits at or above position n have no effect on the choice or the cost.
- R12: The block length J is 16 when `cfg_blk16` is high and 8 when it is low. `out_valid` is a one-cycle pulse that is high during the cycle that begins two clock edges after the edge that captures the last sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_n | input | 5 | Sample width n (2..16), latched at block start |
| cfg_blk16 | input | 1 | 1: J = 16, 0: J = 8, latched at block start |
| cfg_restr | input | 1 | 1: restricted option set, latched at block start |
| in_valid | input | 1 | Residual present |
| in_first | input | 1 | Residual is the first of a block |
| in_res | input | 16 | Mapped residual |
| out_valid | output | 1 | Result pulse |
| out_kind | output | 2 | Chosen option kind (R8 encoding) |
| out_k | output | 4 | Split parameter for kind 2 |
| out_cost | output | 24 | Total bits of the chosen option |
| out_allzero | output | 1 | Every residual in the block was zero |

## Verification
The bench sends several kinds of input to a cost model and compares the choice against it:

- **Random blocks with a spread of magnitudes** separate the split options from one another and from raw.
- **Sparse 0/1 blocks** check whether second extension beats the fundamental sequence.
- **All-zero blocks** confirm that zero block takes precedence in the full set and that the fundamental sequence takes its place in the restricted set.
- **An all-ones block** creates an exact tie between k = 0 and k = 1, which exposes the tie-break order.
- **Upper-bit garbage, the short block length, stray samples in IDLE and a mid-block restart** separate masking, length handling and start handling.

// File: rtl/rice_sel_pkg.sv
package rice_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_COST = 2'd2,
        ST_EMIT = 2'd3
    } sel_state_e;

    typedef enum logic [1:0] {
        OK_ZERO  = 2'd0,
        OK_SECX  = 2'd1,
        OK_SPLIT = 2'd2,
        OK_RAW   = 2'd3
    } opt_kind_e;

    // Option identifier length as a function of sample width.
    function automatic logic [2:0] id_bits(input int unsigned n);
        if (n <= 8)
            return 3'd3;
        else if (n <= 16)
            return 3'd4;
        else
            return 3'd5;
    endfunction

endpackage

// File: rtl/split_sum_bank.sv
module split_sum_bank #(
    parameter int W  = 16,
    parameter int KN = 15,
    parameter int CW = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   add,
    input  logic [W-1:0]           res,
    output logic [KN-1:0][CW-1:0]  sums
);

    // One accumulator per split parameter k: sum of (r >> k) + 1.
    for (genvar g = 0; g < KN; g++) begin : g_k
        logic [CW-1:0] term;

        always_comb term = CW'(res >> g) + CW'(1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sums[g] <= '0;
            else if (load)
                sums[g] <= term;
            else if (add)
                sums[g] <= sums[g] + term;
        end
    end

endmodule

// File: rtl/pair_gamma_acc.sv
module pair_gamma_acc #(
    parameter int W  = 16,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          add,
    input  logic [W-1:0]  res,
    output logic [CW-1:0] acc
);

    // Pair sums at or above this limit saturate the accumulator.
    localparam int SAT_EXP = (CW - 2) / 2;
    localparam logic [W:0] SAT_LIM = (W + 1)'(1) << SAT_EXP;

    logic [W-1:0]  held;
    logic          half;
    logic [W:0]    psum;
    logic [CW-1:0] sx;
    logic [CW-1:0] prod;
    logic [CW-1:0] term;
    logic          big;
    logic [CW:0]   nsum;

    always_comb begin
        psum = {1'b0, held} + {1'b0, res};
        big  = (psum >= SAT_LIM);
        sx   = CW'(psum);
        prod = sx * (sx + CW'(1));
        term = (prod >> 1) + CW'(res) + CW'(1);
        nsum = {1'b0, acc} + {1'b0, term};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
            half <= 1'b0;
            acc  <= '0;
        end else if (load) begin
            held <= res;
            half <= 1'b1;
            acc  <= '0;
        end else if (add) begin
            if (half) begin
                half <= 1'b0;
                acc  <= (big || nsum[CW]) ? '1 : nsum[CW-1:0];
            end else begin
                held <= res;
                half <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/opt_pick.sv
module opt_pick
    import rice_sel_pkg::*;
#(
    parameter int KN = 15,
    parameter int KW = 4,
    parameter int CW = 24
) (
    input  logic [CW-1:0]          c_zero,
    input  logic                   e_zero,
    input  logic [CW-1:0]          c_secx,
    input  logic                   e_secx,
    input  logic [KN-1:0][CW-1:0]  c_split,
    input  logic [KN-1:0]          e_split,
    input  logic [CW-1:0]          c_raw,
    output opt_kind_e              p_kind,
    output logic [KW-1:0]          p_k,
    output logic [CW-1:0]          p_cost
);

    // Walk the options in tie-break order; only a strictly lower total replaces.
    always_comb begin
        logic have;
        have   = 1'b0;
        p_kind = OK_RAW;
        p_k    = '0;
        p_cost = c_raw;
        if (e_zero) begin
            have   = 1'b1;
            p_kind = OK_ZERO;
            p_cost = c_zero;
        end
        if (e_secx && (!have || c_secx < p_cost)) begin
            have   = 1'b1;
            p_kind = OK_SECX;
            p_cost = c_secx;
        end
        for (int i = 0; i < KN; i++) begin
            if (e_split[i] && (!have || c_split[i] < p_cost)) begin
                have   = 1'b1;
                p_kind = OK_SPLIT;
                p_k    = KW'(i);
                p_cost = c_split[i];
            end
        end
        if (!have || c_raw < p_cost) begin
            p_kind = OK_RAW;
            p_k    = '0;
            p_cost = c_raw;
        end
    end

endmodule

// File: rtl/rice_option_selector.sv
module rice_option_selector
    import rice_sel_pkg::*;
#(
    parameter int N_MAX   = 16,
    parameter int J_MAX   = 16,
    parameter int CW      = 24,
    parameter int RESTR_K = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(N_MAX+1)-1:0]     cfg_n,
    input  logic                           cfg_blk16,
    input  logic                           cfg_restr,
    input  logic                           in_valid,
    input  logic                           in_first,
    input  logic [N_MAX-1:0]               in_res,
    output logic                           out_valid,
    output logic [1:0]                     out_kind,
    output logic [$clog2(N_MAX-1)-1:0]     out_k,
    output logic [CW-1:0]                  out_cost,
    output logic                           out_allzero
);

    localparam int KN   = N_MAX - 1;
    localparam int KW   = $clog2(KN);
    localparam int NW   = $clog2(N_MAX + 1);
    localparam int CNTW = $clog2(J_MAX + 1);

    sel_state_e state, state_nx;

    logic [NW-1:0]   n_q;
    logic            jlong_q;
    logic            restr_q;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] jv;
    logic            allz;

    logic            start, add, last;
    logic [NW-1:0]   n_use;
    logic [NW-1:0]   msh;
    logic [N_MAX-1:0] res_m;
    logic [2:0]      idl;

    logic [KN-1:0][CW-1:0] sums;
    logic [CW-1:0]         se_acc;

    // Registered totals, captured in ST_COST.
    logic [KN-1:0][CW-1:0] t_split;
    logic [KN-1:0]         e_split;
    logic [CW-1:0]         t_secx, t_zero, t_raw;
    logic                  e_secx, e_zero;

    opt_kind_e     p_kind;
    logic [KW-1:0] p_k;
    logic [CW-1:0] p_cost;

    // ---------------- input qualification ----------------
    always_comb begin
        start = in_valid && in_first && (state == ST_IDLE || state == ST_FILL);
        add   = in_valid && !in_first && (state == ST_FILL);
        jv    = jlong_q ? CNTW'(J_MAX) : CNTW'(J_MAX / 2);
        last  = add && (cnt == jv - CNTW'(1));
        n_use = start ? cfg_n : n_q;
        msh   = NW'(N_MAX) - n_use;
        res_m = in_res & ({N_MAX{1'b1}} >> msh);
        idl   = id_bits(32'(n_q));
    end

    // ---------------- state register ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_FILL;
            ST_FILL: if (last)  state_nx = ST_COST;
            ST_COST: state_nx = ST_EMIT;
            ST_EMIT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // ---------------- block bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q     <= NW'(N_MAX);
            jlong_q <= 1'b1;
            restr_q <= 1'b0;
            cnt     <= '0;
            allz    <= 1'b0;
        end else if (start) begin
            n_q     <= cfg_n;
            jlong_q <= cfg_blk16;
            restr_q <= cfg_restr;
            cnt     <= CNTW'(1);
            allz    <= (res_m == '0);
        end else if (add) begin
            cnt     <= cnt + CNTW'(1);
            allz    <= allz && (res_m == '0);
        end
    end

    split_sum_bank #(.W(N_MAX), .KN(KN), .CW(CW)) u_split (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .add   (add),
        .res   (res_m),
        .sums  (sums)
    );

    pair_gamma_acc #(.W(N_MAX), .CW(CW)) u_pair (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .add   (add),
        .res   (res_m),
        .acc   (se_acc)
    );

    // ---------------- total cost capture ----------------
    for (genvar g = 0; g < KN; g++) begin : g_tot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                t_split[g] <= '0;
                e_split[g] <= 1'b0;
            end else if (state == ST_COST) begin
                t_split[g] <= sums[g] + CW'(jv) * CW'(g) + CW'(idl);
                e_split[g] <= (g + 2 <= 32'(n_q)) && (!restr_q || g <= RESTR_K);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_secx <= '0;
            t_zero <= '0;
            t_raw  <= '0;
            e_secx <= 1'b0;
            e_zero <= 1'b0;
        end else if (state == ST_COST) begin
            logic [CW:0] sx_sum;
            sx_sum = {1'b0, se_acc} + (CW + 1)'(idl) + (CW + 1)'(1);
            t_secx <= (&se_acc || sx_sum[CW]) ? '1 : sx_sum[CW-1:0];
            t_zero <= CW'(idl) + CW'(2);
            t_raw  <= CW'(jv) * CW'(n_q) + CW'(idl);
            e_secx <= !restr_q;
            e_zero <= !restr_q && allz;
        end
    end

    opt_pick #(.KN(KN), .KW(KW), .CW(CW)) u_pick (
        .c_zero  (t_zero),
        .e_zero  (e_zero),
        .c_secx  (t_secx),
        .e_secx  (e_secx),
        .c_split (t_split),
        .e_split (e_split),
        .c_raw   (t_raw),
        .p_kind  (p_kind),
        .p_k     (p_k),
        .p_cost  (p_cost)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_kind    <= 2'd0;
            out_k       <= '0;
            out_cost    <= '0;
            out_allzero <= 1'b0;
        end else begin
            out_valid <= (state == ST_EMIT);
            if (state == ST_EMIT) begin
                out_kind    <= p_kind;
                out_k       <= p_k;
                out_cost    <= p_cost;
                out_allzero <= allz;
            end
        end
    end

endmodule

// File: rtl/rice_option_selector_chk.sv
module rice_option_selector_chk #(
    parameter int N_MAX   = 16,
    parameter int J_MAX   = 16,
    parameter int CW      = 24,
    parameter int RESTR_K = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [$clog2(N_MAX+1)-1:0]     cfg_n,
    input logic                           cfg_blk16,
    input logic                           cfg_restr,
    input logic                           out_valid,
    input logic [1:0]                     out_kind,
    input logic [$clog2(N_MAX-1)-1:0]     out_k,
    input logic [CW-1:0]                  out_cost,
    input logic                           out_allzero
);

    logic [CW-1:0] raw_lim;
    always_comb begin
        raw_lim = CW'(cfg_blk16 ? J_MAX : J_MAX / 2) * CW'(cfg_n)
                + CW'(rice_sel_pkg::id_bits(32'(cfg_n)));
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R12

    AST_RAW_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cost <= raw_lim); // R5

    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_allzero && !cfg_restr) |-> out_kind == 2'd0); // R7

    AST_RESTR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_restr) |->
            (out_kind == 2'd3 || (out_kind == 2'd2 && 32'(out_k) <= RESTR_K))); // R9

    AST_K_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd2) |-> 32'(out_k) + 2 <= 32'(cfg_n)); // R10

    AST_K_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'd2) |-> out_k == '0); // R8

endmodule

bind rice_option_selector rice_option_selector_chk #(
    .N_MAX(N_MAX), .J_MAX(J_MAX), .CW(CW), .RESTR_K(RESTR_K)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_n       (cfg_n),
    .cfg_blk16   (cfg_blk16),
    .cfg_restr   (cfg_restr),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_k       (out_k),
    .out_cost    (out_cost),
    .out_allzero (out_allzero)
);

// File: tb/rice_option_selector_test.sv
module rice_option_selector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_n = 5'd16;
    logic        cfg_blk16 = 1'b1;
    logic        cfg_restr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic [15:0] in_res = '0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [3:0]  out_k;
    logic [23:0] out_cost;
    logic        out_allzero;

    always #5 clk = ~clk;

    rice_option_selector uut (
        .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .cfg_blk16(cfg_blk16),
        .cfg_restr(cfg_restr), .in_valid(in_valid), .in_first(in_first),
        .in_res(in_res), .out_valid(out_valid), .out_kind(out_kind),
        .out_k(out_k), .out_cost(out_cost), .out_allzero(out_allzero)
    );

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] blk [16];

    int     q_kind[$];
    int     q_k[$];
    longint q_cost[$];
    bit     q_az[$];
    longint q_cyc[$];
    string  q_tag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Cost model written from the requirements.
    task automatic model(input int n, input bit j16, input bit restr,
                         output int kind, output int kk, output longint cost,
                         output bit az);
        int J, id, kmax;
        longint m, c, s;
        longint r [16];
        J  = j16 ? 16 : 8;
        id = (n <= 8) ? 3 : (n <= 16) ? 4 : 5;
        m  = (64'd1 << n) - 1;
        az = 1'b1;
        for (int i = 0; i < J; i++) begin
            r[i] = longint'(blk[i]) & m;
            if (r[i] != 0) az = 1'b0;
        end
        kind = -1; kk = 0; cost = 0;
        if (!restr && az) begin kind = 0; cost = id + 2; end
        if (!restr) begin
            c = id + 1;
            for (int p = 0; p < J; p += 2) begin
                s = r[p] + r[p+1];
                c += s * (s + 1) / 2 + r[p+1] + 1;
            end
            if (kind < 0 || c < cost) begin kind = 1; cost = c; end
        end
        kmax = n - 2;
        if (restr && kmax > 3) kmax = 3;
        for (int k = 0; k <= kmax; k++) begin
            c = id + J * k;
            for (int i = 0; i < J; i++) c += (r[i] >> k) + 1;
            if (kind < 0 || c < cost) begin kind = 2; kk = k; cost = c; end
        end
        c = J * n + id;
        if (kind < 0 || c < cost) begin kind = 3; kk = 0; cost = c; end
    endtask

    // Driver: pushes the expected result, then streams the block.
    task automatic drive_block(input int n, input bit j16, input bit restr,
                               input string tag);
        int kind, kk, J;
        longint cost;
        bit az;
        model(n, j16, restr, kind, kk, cost, az);
        J = j16 ? 16 : 8;
        for (int i = 0; i < J; i++) begin
            @(negedge clk);
            if (i == 0) begin
                cfg_n = 5'(n); cfg_blk16 = j16; cfg_restr = restr;
            end
            in_valid = 1'b1;
            in_first = (i == 0);
            in_res   = blk[i];
            if (i == J - 1) begin
                q_kind.push_back(kind); q_k.push_back(kk);
                q_cost.push_back(cost); q_az.push_back(az);
                q_cyc.push_back(cyc + 3); q_tag.push_back(tag);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_kind.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 1, 0);
            end else begin
                int ek, ekk;
                longint ec, ecy;
                bit ea;
                string t;
                ek = q_kind.pop_front(); ekk = q_k.pop_front();
                ec = q_cost.pop_front(); ea = q_az.pop_front();
                ecy = q_cyc.pop_front(); t = q_tag.pop_front();
                check(32'(out_kind) == ek, t, "kind", out_kind, ek);
                check(32'(out_k) == ekk, t, "k", out_k, ekk);
                check(longint'(out_cost) == ec, t, "cost", out_cost, ec);
                check(out_allzero == ea, t, "allzero", out_allzero, ea);
                check(cyc == ecy, {t, "/R12"}, "result cycle", cyc, ecy);
            end
        end
    end

    function automatic logic [15:0] rnd_val(input int bits);
        if (bits <= 0) return 16'd0;
        return 16'($urandom & ((32'd1 << bits) - 1));
    endfunction

    initial begin
        #1500000;
        check(1'b0, "R12", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int tk, tkk;
        longint tc;
        bit ta;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R3: random magnitudes, several widths
        for (int t = 0; t < 24; t++) begin
            int n, b;
            n = (t % 4 == 0) ? 4 : (t % 4 == 1) ? 8 : (t % 4 == 2) ? 12 : 16;
            b = $urandom_range(0, n);
            for (int i = 0; i < 16; i++) blk[i] = rnd_val(b);
            drive_block(n, 1'b1, 1'b0, "R3");
        end

        // R4: sparse low-entropy blocks
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 16; i++) blk[i] = (($urandom % 6) == 0) ? 16'd1 : 16'd0;
            drive_block(16, 1'b1, 1'b0, "R4");
        end

        // R5: full-range data where raw wins
        for (int i = 0; i < 16; i++) blk[i] = 16'hF000 | rnd_val(12);
        drive_block(16, 1'b1, 1'b0, "R5");

        // R6: same data at n=8 and n=16
        for (int i = 0; i < 16; i++) blk[i] = rnd_val(3);
        drive_block(8, 1'b1, 1'b0, "R6");
        drive_block(16, 1'b1, 1'b0, "R6");

        // R7: all zero, full and restricted
        for (int i = 0; i < 16; i++) blk[i] = 16'd0;
        drive_block(16, 1'b1, 1'b0, "R7");
        drive_block(16, 1'b1, 1'b1, "R7");

        // R8: tie between k=0 and k=1 (36 bits each)
        for (int i = 0; i < 16; i++) blk[i] = 16'd1;
        model(16, 1'b1, 1'b0, tk, tkk, tc, ta);
        check(tk == 2 && tkk == 0 && tc == 36, "R8", "tie model cost", tc, 36);
        drive_block(16, 1'b1, 1'b0, "R8");

        // R9: restricted set with large-k data
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < 16; i++) blk[i] = rnd_val(10 + t);
            drive_block(16, 1'b1, 1'b1, "R9");
        end
        for (int i = 0; i < 16; i++) blk[i] = rnd_val(1);
        drive_block(16, 1'b1, 1'b1, "R9");

        // R10: small n limits k
        for (int i = 0; i < 16; i++) blk[i] = 16'd14 | rnd_val(1);
        drive_block(4, 1'b1, 1'b0, "R10");

        // R11: garbage above n
        for (int i = 0; i < 16; i++) blk[i] = 16'hAB00 | rnd_val(2);
        drive_block(8, 1'b1, 1'b0, "R11");
        for (int i = 0; i < 16; i++) blk[i] = 16'hFF00;
        drive_block(8, 1'b1, 1'b0, "R11");

        // R12: short block length
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < 16; i++) blk[i] = rnd_val(t * 3);
            drive_block(12, 1'b0, 1'b0, "R12");
        end

        // R2: stray samples in IDLE are ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); in_valid = 1'b1; in_first = 1'b0; in_res = 16'h7777;
        end
        @(negedge clk); in_valid = 1'b0;
        for (int i = 0; i < 16; i++) blk[i] = rnd_val(2);
        drive_block(16, 1'b1, 1'b0, "R2");

        // R2: restart mid-block
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); in_valid = 1'b1; in_first = (i == 0); in_res = 16'h3FFF;
        end
        for (int i = 0; i < 16; i++) blk[i] = rnd_val(1);
        drive_block(16, 1'b1, 1'b0, "R2");

        repeat (5) @(negedge clk);
        check(q_kind.size() == 0, "R12", "results outstanding", q_kind.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule